// File: doc/BRIEF.md
# Write-Back Data Cache Miss Controller

This block sits between a load/store core and a 64-bit system bus and controls a four-way set-associative write-back data cache with 32-byte lines. A core request is looked up in the tag and state array. A hit is served from the line storage without any bus traffic. A read miss, or a store miss, which is handled as a read with intent to modify, selects the least-recently-used way of the indexed set. If that way holds modified data, the old line is first written out as a four-beat burst. The new line is then fetched with a four-beat burst read.

Stores to write-through pages, accesses to caching-inhibited pages, and every access made while the cache enable input is low go to the bus as one single beat of 1 to 8 bytes. The address is passed through unchanged, so it may be unaligned. A burst/single signal tells the bus which kind of transaction is running.

The core side is a valid/ready stream. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. Only one request is in flight at a time. A response is offered on `rsp_valid` and is held, with its data stable, until `rsp_ready` is seen, so the core applies back-pressure through `rsp_ready`. The bus side is request/grant followed by one acknowledge per beat.

Top module: `wbm_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `bus_req` is 0, every line is invalid and set ages rank way 3 as least recently used.
- R2: A read miss runs one burst read (`bus_burst`=1, `bus_write`=0) at the line address with bits 4:0 zero. The response carries the doubleword chosen by address bits 4:3 from the refilled line.
- R3: When the victim is modified, a burst write of the victim line runs first. Its address is the victim line address and its four doublewords go in ascending order. The refill read starts only after that write ends. A clean or invalid victim causes no write.
- R4: The victim is the least-recently-used way of the set. Every hit, and the lookup that follows every fill, makes the touched way the most recent.
- R5: A store miss to a page that is not write-through refills the line with a burst read and no bus write. It then merges the store bytes into the line, where `req_be` bit i selects bits 8i+7:8i, and marks the line modified.
- R6: A cacheable hit causes no bus transaction. A read hit returns the cached doubleword, and a store hit merges its enabled bytes into the line.
- R7: A write-through store runs one single-beat write (`bus_burst`=0) with the core's address, byte enables and data. On a hit it also updates the line without marking it modified. On a miss it allocates nothing.
- R8: With `req_inh` set or `cache_en` low at acceptance, the access runs as one single-beat transaction with the core's address and enables. The cache is neither read nor changed, and a read returns the bus data.
- R9: `bus_req` stays high with a stable address, direction and burst flag until `bus_gnt`. Burst addresses are 32-byte aligned.
- R10: `req_ready` is high only when no request is in flight. `rsp_valid` is held with stable `rsp_rdata` until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | Cache enable, sampled when a request is accepted |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Store data, byte i on bits 8i+7:8i |
| req_be | input | 8 | Byte enables |
| req_wt | input | 1 | Page is write-through |
| req_inh | input | 1 | Page is caching-inhibited |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Core accepts the response |
| rsp_rdata | output | 64 | Load data |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Bus grant, one cycle |
| bus_addr | output | ADDR_W | Transaction address |
| bus_write | output | 1 | 1 = write transaction |
| bus_burst | output | 1 | 1 = four-beat burst, 0 = single beat |
| bus_be | output | 8 | Byte enables, all ones for bursts |
| bus_wdata | output | 64 | Write data for the current beat |
| bus_ack | input | 1 | Beat acknowledge |
| bus_rdata | input | 64 | Read data, valid with `bus_ack` |

## Verification
A request is captured on the accepting edge. It is looked up on the next edge. A hit raises `rsp_valid` right after that second edge. A single beat or burst shows its response one edge after the final `bus_ack`, or two edges after it when a refill is followed by the repeat lookup. A cast-out leads to a refill request one edge after its last acknowledge. The bench drives and samples only on falling edges. It waits for `rsp_valid` with a bounded poll rather than at a fixed offset, and it records every bus beat in the cycle where the bench itself raises `bus_ack`. Each scenario then compares the logged transactions and the response against values derived from the requirements and a fixed memory pattern.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  localparam int unsigned WAYS  = 4;
  localparam int unsigned WAY_W = 2;
  localparam int unsigned BEATS = 4;
  localparam int unsigned BT_W  = 2;
  localparam int unsigned OFF_W = 5;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_CAST_REQ, S_CAST_DAT,
    S_FILL_REQ, S_FILL_DAT, S_ONE_REQ, S_ONE_DAT, S_RESP
  } wbm_state_e;

  typedef logic [BEATS-1:0][63:0] line_t;

  function automatic logic [63:0] merge_bytes(input logic [63:0] old_d,
                                              input logic [63:0] new_d,
                                              input logic [7:0]  be);
    logic [63:0] r;
    for (int i = 0; i < 8; i++)
      r[8*i +: 8] = be[i] ? new_d[8*i +: 8] : old_d[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/wbm_lru.sv
module wbm_lru
  import wbm_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [IDX_W-1:0] query_set,
  output logic [WAY_W-1:0] victim_way
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [WAYS-1:0][WAY_W-1:0] ages_all [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [WAYS-1:0][WAY_W-1:0] ages;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WAYS; w++) ages[w] <= WAY_W'(w);
      end else if (touch_en && touch_set == IDX_W'(s)) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == touch_way) ages[w] <= '0;
          else if (ages[w] < ages[touch_way]) ages[w] <= ages[w] + 1'b1;
        end
      end
    end
    assign ages_all[s] = ages;

    // R4: the ages of a set always form an ordering of the four ways
    p_age_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ages[0] != ages[1]) && (ages[0] != ages[2]) && (ages[0] != ages[3]) &&
      (ages[1] != ages[2]) && (ages[1] != ages[3]) && (ages[2] != ages[3]))
      else $error("set ages not distinct");
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (ages_all[query_set][w] == WAY_W'(WAYS-1)) victim_way = WAY_W'(w);
  end
endmodule

// File: rtl/wbm_tags.sv
module wbm_tags
  import wbm_pkg::*;
#(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way,
  input  logic [WAY_W-1:0] vic_way,
  output logic             vic_valid,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             inst_en,
  input  logic [WAY_W-1:0] inst_way,
  input  logic [TAG_W-1:0] inst_tag,
  input  logic             mark_en,
  input  logic [WAY_W-1:0] mark_way
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  val_q [SETS];
  logic [WAYS-1:0]  dty_q [SETS];
  logic [WAYS-1:0]  hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = val_q[set_idx][w] && (tag_q[set_idx][w] == look_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end
  assign hit       = |hit_vec;
  assign vic_valid = val_q[set_idx][vic_way];
  assign vic_dirty = dty_q[set_idx][vic_way];
  assign vic_tag   = tag_q[set_idx][vic_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        dty_q[s] <= '0;
      end
    end else begin
      if (inst_en) begin
        val_q[set_idx][inst_way] <= 1'b1;
        dty_q[set_idx][inst_way] <= 1'b0;
      end
      if (mark_en) dty_q[set_idx][mark_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[set_idx][inst_way] <= inst_tag;
  end

  // R6: a tag can match in at most one way of a set
  p_one_way_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)) else $error("tag matches in several ways");
endmodule

// File: rtl/wbm_lines.sv
module wbm_lines
  import wbm_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [WAY_W-1:0] rd_way,
  output line_t            rd_line,
  input  logic             wr_en,
  input  logic [WAY_W-1:0] wr_way,
  input  logic [BT_W-1:0]  wr_beat,
  input  logic [63:0]      wr_data,
  input  logic [7:0]       wr_be
);
  localparam int unsigned SETS  = 1 << IDX_W;
  localparam int unsigned DEPTH = SETS * WAYS * BEATS;
  localparam int unsigned A_W   = IDX_W + WAY_W + BT_W;

  logic [63:0] mem [DEPTH];
  logic [A_W-1:0] wr_a;

  assign wr_a = {set_idx, wr_way, wr_beat};

  for (genvar b = 0; b < BEATS; b++) begin : g_rd
    assign rd_line[b] = mem[{set_idx, rd_way, BT_W'(b)}];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_a] <= merge_bytes(mem[wr_a], wr_data, wr_be);
  end
endmodule

// File: rtl/wbm_ctrl.sv
module wbm_ctrl
  import wbm_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [7:0]        req_be,
  input  logic              req_wt,
  input  logic              req_inh,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic              bus_burst,
  output logic [7:0]        bus_be,
  output logic [63:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [63:0]       bus_rdata
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [BT_W-1:0] LAST_BEAT = BT_W'(BEATS - 1);

  wbm_state_e state;
  logic              q_write, q_wt, q_inh, q_en;
  logic [ADDR_W-1:0] q_addr;
  logic [63:0]       q_wdata, rsp_q;
  logic [7:0]        q_be;
  logic [WAY_W-1:0]  vic_way_q;
  logic [TAG_W-1:0]  vic_tag_q;
  logic [BT_W-1:0]   beat_q;
  line_t             cast_buf;

  logic [IDX_W-1:0]  q_set;
  logic [TAG_W-1:0]  q_tag;
  logic [BT_W-1:0]   q_dw;
  logic              bypass;

  assign q_set  = q_addr[OFF_W +: IDX_W];
  assign q_tag  = q_addr[ADDR_W-1 -: TAG_W];
  assign q_dw   = q_addr[3 +: BT_W];
  assign bypass = !q_en || q_inh;

  // lookup, replacement and storage
  logic             hit, vic_valid, vic_dirty;
  logic [WAY_W-1:0] hit_way, lru_victim, rd_way, wr_way;
  logic [TAG_W-1:0] vic_tag;
  line_t            rd_line;
  logic             touch_en, inst_en, mark_en, wr_en;
  logic [BT_W-1:0]  wr_beat;
  logic [63:0]      wr_data;
  logic [7:0]       wr_be;

  wbm_lru #(.IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .touch_en(touch_en), .touch_set(q_set), .touch_way(hit_way),
    .query_set(q_set), .victim_way(lru_victim)
  );

  wbm_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .set_idx(q_set), .look_tag(q_tag),
    .hit(hit), .hit_way(hit_way),
    .vic_way(lru_victim), .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .inst_en(inst_en), .inst_way(vic_way_q), .inst_tag(q_tag),
    .mark_en(mark_en), .mark_way(hit_way)
  );

  wbm_lines #(.IDX_W(IDX_W)) u_lines (
    .clk(clk), .set_idx(q_set), .rd_way(rd_way), .rd_line(rd_line),
    .wr_en(wr_en), .wr_way(wr_way), .wr_beat(wr_beat),
    .wr_data(wr_data), .wr_be(wr_be)
  );

  assign rd_way = hit ? hit_way : lru_victim;

  always_comb begin
    touch_en = 1'b0;
    mark_en  = 1'b0;
    inst_en  = 1'b0;
    wr_en    = 1'b0;
    wr_way   = hit_way;
    wr_beat  = q_dw;
    wr_data  = q_wdata;
    wr_be    = q_be;
    if (state == S_LOOK && !bypass && hit) begin
      touch_en = 1'b1;
      if (q_write) begin
        wr_en   = 1'b1;
        mark_en = !q_wt;
      end
    end
    if (state == S_FILL_DAT && bus_ack) begin
      wr_en   = 1'b1;
      wr_way  = vic_way_q;
      wr_beat = beat_q;
      wr_data = bus_rdata;
      wr_be   = '1;
      inst_en = (beat_q == LAST_BEAT);
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      q_write   <= 1'b0;
      q_wt      <= 1'b0;
      q_inh     <= 1'b0;
      q_en      <= 1'b0;
      q_addr    <= '0;
      q_wdata   <= '0;
      q_be      <= '0;
      rsp_q     <= '0;
      vic_way_q <= '0;
      vic_tag_q <= '0;
      beat_q    <= '0;
      cast_buf  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          q_write <= req_write;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          q_be    <= req_be;
          q_wt    <= req_wt;
          q_inh   <= req_inh;
          q_en    <= cache_en;
          state   <= S_LOOK;
        end
        S_LOOK: begin
          if (bypass) begin
            state <= S_ONE_REQ;
          end else if (hit) begin
            if (q_write) begin
              state <= q_wt ? S_ONE_REQ : S_RESP;
            end else begin
              rsp_q <= rd_line[q_dw];
              state <= S_RESP;
            end
          end else if (q_write && q_wt) begin
            state <= S_ONE_REQ;
          end else begin
            vic_way_q <= lru_victim;
            vic_tag_q <= vic_tag;
            cast_buf  <= rd_line;
            state     <= (vic_valid && vic_dirty) ? S_CAST_REQ : S_FILL_REQ;
          end
        end
        S_CAST_REQ: if (bus_gnt) begin
          beat_q <= '0;
          state  <= S_CAST_DAT;
        end
        S_CAST_DAT: if (bus_ack) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state <= S_FILL_REQ;
        end
        S_FILL_REQ: if (bus_gnt) begin
          beat_q <= '0;
          state  <= S_FILL_DAT;
        end
        S_FILL_DAT: if (bus_ack) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) state <= S_LOOK;
        end
        S_ONE_REQ: if (bus_gnt) state <= S_ONE_DAT;
        S_ONE_DAT: if (bus_ack) begin
          if (!q_write) rsp_q <= bus_rdata;
          state <= S_RESP;
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // bus and core outputs
  logic in_cast, in_fill;
  assign in_cast = (state == S_CAST_REQ) || (state == S_CAST_DAT);
  assign in_fill = (state == S_FILL_REQ) || (state == S_FILL_DAT);

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_RESP);
  assign rsp_rdata = rsp_q;
  assign bus_req   = (state == S_CAST_REQ) || (state == S_FILL_REQ) || (state == S_ONE_REQ);
  assign bus_burst = in_cast || in_fill;
  assign bus_write = in_cast ? 1'b1 : (in_fill ? 1'b0 : q_write);
  assign bus_be    = bus_burst ? 8'hFF : q_be;
  assign bus_wdata = in_cast ? cast_buf[beat_q] : q_wdata;

  always_comb begin
    if (in_cast)      bus_addr = {vic_tag_q, q_set, OFF_W'(0)};
    else if (in_fill) bus_addr = {q_tag, q_set, OFF_W'(0)};
    else              bus_addr = q_addr;
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_burst) && $stable(bus_write)))
    else $error("bus request dropped or changed before grant");

  p_burst_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_burst) |-> (bus_addr[OFF_W-1:0] == '0))
    else $error("burst address not line aligned");

  p_cast_then_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CAST_DAT && bus_ack && beat_q == LAST_BEAT) |=> (bus_req && bus_burst && !bus_write))
    else $error("refill did not follow cast-out");

  p_bypass_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bypass) |-> !bus_burst)
    else $error("bypassed access issued a burst");

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)))
    else $error("response dropped or changed under back-pressure");

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !bus_req))
    else $error("ready while busy");
endmodule

// File: tb/test_wbm_ctrl.sv
module test_wbm_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cache_en = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_wt = 1'b0, req_inh = 1'b0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic rsp_ready = 1'b1;
  logic req_ready, rsp_valid, bus_req, bus_write, bus_burst;
  logic [63:0] rsp_rdata, bus_wdata;
  logic [31:0] bus_addr;
  logic [7:0]  bus_be;
  logic bus_gnt = 1'b0, bus_ack = 1'b0;
  logic [63:0] bus_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wbm_ctrl i_wbm_ctrl (
    .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .req_wt(req_wt), .req_inh(req_inh),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_burst(bus_burst), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [31:0] a);
    logic [31:0] x;
    x = {a[31:3], 3'b000};
    return {x ^ 32'h5EED_0000, ~x};
  endfunction

  function automatic logic [63:0] mrg(input logic [63:0] o, input logic [63:0] n,
                                      input logic [7:0] be);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = be[i] ? n[8*i +: 8] : o[8*i +: 8];
    return r;
  endfunction

  // bus log and responder
  int          tx_n = 0;
  logic [31:0] tx_addr  [8];
  logic        tx_burst [8];
  logic        tx_write [8];
  logic [7:0]  tx_be    [8];
  logic [63:0] tx_wd    [8][4];

  initial begin
    forever begin
      @(negedge clk);
      if (bus_req && rst_n) begin
        logic [31:0] a;
        int k, nb;
        a = bus_addr;
        k = tx_n;
        if (k < 8) begin
          tx_addr[k] = a; tx_burst[k] = bus_burst;
          tx_write[k] = bus_write; tx_be[k] = bus_be;
        end
        for (int i = 0; i < 2; i++) begin
          @(negedge clk);
          chk(bus_req && bus_addr == a, "R9", "request held before grant", {32'h0, bus_addr}, {32'h0, a});
        end
        nb = bus_burst ? 4 : 1;
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        for (int b = 0; b < nb; b++) begin
          bus_rdata = pat(a + 32'(8 * b));
          bus_ack = 1'b1;
          if (k < 8) tx_wd[k][b] = bus_wdata;
          @(negedge clk);
          bus_ack = 1'b0;
          @(negedge clk);
        end
        tx_n++;
      end
    end
  end

  task automatic do_req(input logic w, input logic [31:0] a, input logic [63:0] d,
                        input logic [7:0] be, input logic wt, input logic inh,
                        output logic [63:0] rd);
    int n;
    @(negedge clk);
    tx_n = 0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_be = be; req_wt = wt; req_inh = inh;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid, "R10", "response arrives", {63'h0, rsp_valid}, 64'h1);
    rd = rsp_rdata;
    if (!rsp_ready) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == rd && !req_ready, "R10", "response held under back-pressure",
            rsp_rdata, rd);
      end
      rsp_ready = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic chk_one(input string rq, input logic [31:0] a, input logic wr,
                         input logic [7:0] be, input logic [63:0] wd);
    chk(tx_n == 1, rq, "single tx count", 64'(tx_n), 64'd1);
    chk(tx_burst[0] == 1'b0 && tx_write[0] == wr && tx_be[0] == be, rq, "single kind",
        {55'h0, tx_burst[0], tx_write[0], tx_be[0]}, {55'h0, 1'b0, wr, be});
    chk(tx_addr[0] == a, rq, "single address", {32'h0, tx_addr[0]}, {32'h0, a});
    if (wr) chk(tx_wd[0][0] == wd, rq, "single data", tx_wd[0][0], wd);
  endtask

  task automatic chk_burst(input string rq, input int idx, input logic [31:0] a, input logic wr);
    chk(tx_burst[idx] == 1'b1 && tx_write[idx] == wr, rq, "burst kind",
        {62'h0, tx_burst[idx], tx_write[idx]}, {62'h0, 1'b1, wr});
    chk(tx_addr[idx] == a, rq, "burst address", {32'h0, tx_addr[idx]}, {32'h0, a});
  endtask

  logic [63:0] rd;
  localparam logic [63:0] D1 = 64'h1111_2222_3333_4444;
  localparam logic [63:0] D2 = 64'hDEAD_BEEF_0123_4567;
  localparam logic [63:0] D3 = 64'hA1B2_C3D4_E5F6_0718;

  task automatic t_reset;
    chk(req_ready && !rsp_valid && !bus_req, "R1", "reset outputs",
        {61'h0, req_ready, rsp_valid, bus_req}, 64'h4);
  endtask

  task automatic t_read_miss;
    do_req(1'b0, 32'h1018, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 1, "R2", "read miss tx count", 64'(tx_n), 64'd1);
    chk_burst("R2", 0, 32'h1000, 1'b0);
    chk(rd == pat(32'h1018), "R2", "read miss data", rd, pat(32'h1018));
  endtask

  task automatic t_hits;
    do_req(1'b0, 32'h1008, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 0, "R6", "read hit no bus", 64'(tx_n), 64'd0);
    chk(rd == pat(32'h1008), "R6", "read hit data", rd, pat(32'h1008));
    do_req(1'b1, 32'h2008, D1, 8'h0F, 1'b0, 1'b0, rd);
    chk(tx_n == 1, "R5", "store miss only refill", 64'(tx_n), 64'd1);
    chk_burst("R5", 0, 32'h2000, 1'b0);
    do_req(1'b1, 32'h1000, D2, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 0, "R6", "store hit no bus", 64'(tx_n), 64'd0);
    do_req(1'b0, 32'h1000, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(rd == D2, "R6", "store hit merged", rd, D2);
  endtask

  task automatic t_castout;
    do_req(1'b0, 32'h3000, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 1, "R3", "invalid victim no write", 64'(tx_n), 64'd1);
    do_req(1'b0, 32'h4000, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 1, "R3", "invalid victim no write", 64'(tx_n), 64'd1);
    do_req(1'b0, 32'h5000, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 2, "R3", "dirty victim two tx", 64'(tx_n), 64'd2);
    chk_burst("R4", 0, 32'h2000, 1'b1);
    chk(tx_wd[0][0] == pat(32'h2000), "R3", "cast beat 0", tx_wd[0][0], pat(32'h2000));
    chk(tx_wd[0][1] == mrg(pat(32'h2008), D1, 8'h0F), "R5", "cast beat 1 merged",
        tx_wd[0][1], mrg(pat(32'h2008), D1, 8'h0F));
    chk(tx_wd[0][3] == pat(32'h2018), "R3", "cast beat 3", tx_wd[0][3], pat(32'h2018));
    chk_burst("R3", 1, 32'h5000, 1'b0);
    chk(rd == pat(32'h5000), "R2", "refill data after cast", rd, pat(32'h5000));
  endtask

  task automatic t_lru_touch;
    do_req(1'b0, 32'h3000, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 0, "R4", "touch hit", 64'(tx_n), 64'd0);
    do_req(1'b0, 32'h6000, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 2, "R4", "oldest dirty line cast", 64'(tx_n), 64'd2);
    chk_burst("R4", 0, 32'h1000, 1'b1);
    chk(tx_wd[0][0] == D2, "R3", "cast carries store", tx_wd[0][0], D2);
    chk(tx_wd[0][2] == pat(32'h1010), "R3", "cast beat 2", tx_wd[0][2], pat(32'h1010));
    do_req(1'b0, 32'h7000, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 1, "R3", "clean victim no write", 64'(tx_n), 64'd1);
    chk_burst("R4", 0, 32'h7000, 1'b0);
  endtask

  task automatic t_write_through;
    do_req(1'b1, 32'h3010, D3, 8'h30, 1'b1, 1'b0, rd);
    chk_one("R7", 32'h3010, 1'b1, 8'h30, D3);
    do_req(1'b0, 32'h3010, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 0 && rd == mrg(pat(32'h3010), D3, 8'h30), "R7", "write-through hit updates line",
        rd, mrg(pat(32'h3010), D3, 8'h30));
    do_req(1'b1, 32'h8000, D3, 8'hFF, 1'b1, 1'b0, rd);
    chk_one("R7", 32'h8000, 1'b1, 8'hFF, D3);
    do_req(1'b0, 32'h8000, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 1, "R7", "write-through miss not allocated", 64'(tx_n), 64'd1);
    chk_burst("R7", 0, 32'h8000, 1'b0);
  endtask

  task automatic t_bypass;
    do_req(1'b0, 32'h3018, '0, 8'hFF, 1'b0, 1'b1, rd);
    chk_one("R8", 32'h3018, 1'b0, 8'hFF, '0);
    chk(rd == pat(32'h3018), "R8", "inhibited read data", rd, pat(32'h3018));
    cache_en = 1'b0;
    do_req(1'b1, 32'h300B, D3, 8'h01, 1'b0, 1'b0, rd);
    chk_one("R8", 32'h300B, 1'b1, 8'h01, D3);
    cache_en = 1'b1;
    do_req(1'b0, 32'h3008, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(tx_n == 0 && rd == pat(32'h3008), "R8", "disabled store left line alone", rd, pat(32'h3008));
  endtask

  task automatic t_backpressure;
    rsp_ready = 1'b0;
    do_req(1'b0, 32'h3000, '0, 8'hFF, 1'b0, 1'b0, rd);
    chk(rd == pat(32'h3000), "R10", "held response data", rd, pat(32'h3000));
    chk(req_ready && !rsp_valid, "R10", "ready after response taken",
        {62'h0, req_ready, rsp_valid}, 64'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_miss;
    t_hits;
    t_castout;
    t_lru_touch;
    t_write_through;
    t_bypass;
    t_backpressure;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule